// File: doc/BRIEF.md
# Request Merge Node with Route Breadcrumb

This block joins several upstream requesters onto one downstream port of a 64-bit packet interconnect that splits each transaction into a request and a response. It has 2 or 4 upstream ports. Each upstream port and the downstream port carry two channels, one for requests and one for responses. Each channel is a 64-bit beat with a valid/ready handshake. A packet starts with one header beat. A write request carries data beats after its header. A read response also carries data beats. Read requests and write responses are a header beat alone.

A round-robin arbiter chooses among the upstream ports that have a header waiting. The chosen packet is forwarded whole. As the header passes, the block shifts the header's 8-bit route byte left by log2(N) bits and writes the source port number into the freed low bits.

On the way back, the block reads the low log2(N) bits of the response header's route byte to find the upstream port. It shifts the route byte right by the same amount, so the next node up the tree sees its own breadcrumb in the low bits. The block keeps no table of outstanding transactions. Response order and the number of requests in flight are therefore set only by the requesters and completers.

Header layout, used on both paths:
- bits [63:56]: route byte.
- bit 55: write flag.
- bits [53:48]: 6-bit length L.
- all other bits pass through untouched.

A packet that carries data has exactly L data beats after its header. L = 0 means a header-only packet.

Top module: `rmerge_node`

## Requirements
- R1: After reset, with all inputs low, dnReqValid, every bit of upReqReady and every bit of upRspValid are 0.
- R2: When a request header is forwarded from upstream port p, dnReqData equals that header with route byte [63:56] replaced by ((route << log2(N)) | p), truncated to 8 bits. All other bits are unchanged.
- R3: The grant goes to the first upstream port with a pending header, searching upward from the port after the last granted header and wrapping around. After reset the last grant is taken as port N-1, so port 0 has first priority.
- R4: A write request (bit 55 = 1) with length L > 0 holds the grant until its L data beats have passed. Data beats from other ports never appear in between. Data beats are forwarded unchanged. Read requests with any L are single-beat packets.
- R5: dnReqValid is high only when the port holding the grant presents a beat. upReqReady is high only on that port, and only when dnReqValid and dnReqReady are both high. While dnReqReady is low, the presented beat and the grant do not change.
- R6: A port can issue headers on consecutive cycles without waiting for responses. Three read requests from one port, with ready held high, are accepted in three consecutive cycles.
- R7: A response header goes to the upstream port given by route bits [57:56] (for N=4), and only that port's upRspValid goes high. Its route byte is delivered shifted right by log2(N), with zeros filling the top bits.
- R8: A read response (bit 55 = 0) with length L > 0 sends its L data beats, unchanged, to the same port as its header, whatever bits those data beats hold. A write response is a single beat whatever its length field.
- R9: While dnRspValid is high, dnRspReady equals upRspReady of the port that currently receives the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| upReqValid | input | NUM_UP | Request beat valid, one bit per upstream port |
| upReqReady | output | NUM_UP | Request beat accepted, one bit per upstream port |
| upReqData | input | NUM_UP*64 | Request beats, port p in bits [p*64 +: 64] |
| dnReqValid | output | 1 | Merged request beat valid |
| dnReqReady | input | 1 | Downstream accepts the request beat |
| dnReqData | output | 64 | Merged request beat, with the route stamped on headers |
| dnRspValid | input | 1 | Response beat valid from downstream |
| dnRspReady | output | 1 | Response beat accepted |
| dnRspData | input | 64 | Response beat from downstream |
| upRspValid | output | NUM_UP | Response beat valid, one bit per upstream port |
| upRspReady | input | NUM_UP | Upstream port accepts the response beat |
| upRspData | output | NUM_UP*64 | Response beat copied to every port, route shifted on headers |

## Verification
The hardest case to reach is a header that is presented but stalled by downstream backpressure while a port of higher round-robin priority becomes valid. The grant must stay put even though a fresh arbitration would now pick a different port. A similar case arises when a granted write packet's data beats arrive with gaps: the merge must wait and not hand the grant to another port.

The stimulus reaches both cases with held valids, random arrival of mixed packets on all ports, and low downstream ready for long stretches. A behavioural model in the bench predicts every port on every cycle. Directed sequences cover all ports contending at once straight after reset, and back-to-back reads from one port.

// File: rtl/rmerge_pkg.sv
package rmerge_pkg;
  localparam int BEAT_W    = 64;
  localparam int ROUTE_W   = 8;
  localparam int ROUTE_LSB = 56;
  localparam int WR_BIT    = 55;
  localparam int LEN_LSB   = 48;
  localparam int LEN_W     = 6;

  typedef logic [ROUTE_W-1:0] port_idx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      reqHdr;
    logic      rspHdr;
    port_idx_t reqSel;
  } mrg_strobe_t;

  // header fields decoded by the datapath for control
  typedef struct packed {
    logic             reqWrite;
    logic [LEN_W-1:0] reqLen;
    logic             rspWrite;
    logic [LEN_W-1:0] rspLen;
    port_idx_t        rspDest;
  } mrg_hdr_t;
endpackage

// File: rtl/rmerge_rr.sv
module rmerge_rr
  import rmerge_pkg::*;
#(
  parameter int NUM_UP = 4
) (
  input  logic [NUM_UP-1:0] reqMask,
  input  port_idx_t         lastGrant,
  output port_idx_t         pick,
  output logic              found
);
  always_comb begin
    pick  = lastGrant;
    found = 1'b0;
    for (int k = 1; k <= NUM_UP; k++) begin
      int cand;
      cand = (int'(lastGrant) + k) % NUM_UP;
      if (!found && reqMask[cand]) begin
        found = 1'b1;
        pick  = port_idx_t'(cand);
      end
    end
  end
endmodule

// File: rtl/rmerge_dp.sv
module rmerge_dp
  import rmerge_pkg::*;
#(
  parameter int NUM_UP = 4
) (
  input  logic [NUM_UP*BEAT_W-1:0] upReqData,
  output logic [BEAT_W-1:0]        dnReqData,
  input  logic [BEAT_W-1:0]        dnRspData,
  output logic [NUM_UP*BEAT_W-1:0] upRspData,
  input  mrg_strobe_t              strb,
  output mrg_hdr_t                 info
);
  localparam int SEL_W  = $clog2(NUM_UP);
  localparam int KEEP_W = ROUTE_W - SEL_W;

  logic [BEAT_W-1:0] selBeat;
  logic [BEAT_W-1:0] stamped;
  logic [BEAT_W-1:0] rspShifted;
  logic [BEAT_W-1:0] rspBeat;

  // request mux by granted port
  always_comb begin
    selBeat = '0;
    for (int i = 0; i < NUM_UP; i++) begin
      if (strb.reqSel == port_idx_t'(i)) selBeat = upReqData[i*BEAT_W +: BEAT_W];
    end
  end

  // breadcrumb push on request header
  always_comb begin
    stamped = selBeat;
    stamped[ROUTE_LSB +: ROUTE_W] = {selBeat[ROUTE_LSB +: KEEP_W], strb.reqSel[SEL_W-1:0]};
    dnReqData = strb.reqHdr ? stamped : selBeat;
  end

  // breadcrumb pop on response header
  always_comb begin
    rspShifted = dnRspData;
    rspShifted[ROUTE_LSB +: ROUTE_W] = {{SEL_W{1'b0}}, dnRspData[ROUTE_LSB+SEL_W +: KEEP_W]};
    rspBeat = strb.rspHdr ? rspShifted : dnRspData;
  end

  for (genvar g = 0; g < NUM_UP; g++) begin : gRspFan
    assign upRspData[g*BEAT_W +: BEAT_W] = rspBeat;
  end

  always_comb begin
    info.reqWrite = selBeat[WR_BIT];
    info.reqLen   = selBeat[LEN_LSB +: LEN_W];
    info.rspWrite = dnRspData[WR_BIT];
    info.rspLen   = dnRspData[LEN_LSB +: LEN_W];
    info.rspDest  = port_idx_t'(dnRspData[ROUTE_LSB +: SEL_W]);
  end
endmodule

// File: rtl/rmerge_ctrl.sv
module rmerge_ctrl
  import rmerge_pkg::*;
#(
  parameter int NUM_UP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_UP-1:0] upReqValid,
  output logic [NUM_UP-1:0] upReqReady,
  output logic              dnReqValid,
  input  logic              dnReqReady,
  input  logic              dnRspValid,
  output logic              dnRspReady,
  output logic [NUM_UP-1:0] upRspValid,
  input  logic [NUM_UP-1:0] upRspReady,
  input  mrg_hdr_t          info,
  output mrg_strobe_t       strb
);
  port_idx_t        lastGrant, rrPick, reqSel, reqHoldIdx;
  logic             rrFound, reqHold, reqInData, selValid, reqFire;
  logic [LEN_W-1:0] reqRemain;

  port_idx_t        rspSel, rspHoldIdx;
  logic             rspInData, rspFire;
  logic [LEN_W-1:0] rspRemain;

  rmerge_rr #(.NUM_UP(NUM_UP)) u_rr (
    .reqMask  (upReqValid),
    .lastGrant(lastGrant),
    .pick     (rrPick),
    .found    (rrFound)
  );

  // request side selection and handshake
  always_comb begin
    reqSel   = reqHold ? reqHoldIdx : rrPick;
    selValid = 1'b0;
    for (int i = 0; i < NUM_UP; i++) begin
      if (reqSel == port_idx_t'(i)) selValid = upReqValid[i];
    end
    dnReqValid = reqHold ? selValid : rrFound;
    reqFire    = dnReqValid && dnReqReady;
    for (int i = 0; i < NUM_UP; i++) begin
      upReqReady[i] = (reqSel == port_idx_t'(i)) && reqFire;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastGrant  <= port_idx_t'(NUM_UP - 1);
      reqHold    <= 1'b0;
      reqHoldIdx <= '0;
      reqInData  <= 1'b0;
      reqRemain  <= '0;
    end else if (reqFire) begin
      if (!reqInData) begin
        lastGrant <= reqSel;
        if (info.reqWrite && (info.reqLen != '0)) begin
          reqInData  <= 1'b1;
          reqRemain  <= info.reqLen;
          reqHold    <= 1'b1;
          reqHoldIdx <= reqSel;
        end else begin
          reqHold <= 1'b0;
        end
      end else begin
        reqRemain <= reqRemain - 1'b1;
        if (reqRemain == LEN_W'(1)) begin
          reqInData <= 1'b0;
          reqHold   <= 1'b0;
        end
      end
    end else if (dnReqValid && !reqHold) begin
      // stalled header: freeze the choice
      reqHold    <= 1'b1;
      reqHoldIdx <= reqSel;
    end
  end

  // response side routing
  always_comb begin
    rspSel     = rspInData ? rspHoldIdx : info.rspDest;
    dnRspReady = 1'b0;
    for (int i = 0; i < NUM_UP; i++) begin
      upRspValid[i] = dnRspValid && (rspSel == port_idx_t'(i));
      if (rspSel == port_idx_t'(i)) dnRspReady = upRspReady[i];
    end
    rspFire = dnRspValid && dnRspReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspInData  <= 1'b0;
      rspHoldIdx <= '0;
      rspRemain  <= '0;
    end else if (rspFire) begin
      if (!rspInData) begin
        if (!info.rspWrite && (info.rspLen != '0)) begin
          rspInData  <= 1'b1;
          rspRemain  <= info.rspLen;
          rspHoldIdx <= rspSel;
        end
      end else begin
        rspRemain <= rspRemain - 1'b1;
        if (rspRemain == LEN_W'(1)) rspInData <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.reqHdr = !reqInData;
    strb.rspHdr = !rspInData;
    strb.reqSel = reqSel;
  end
endmodule

// File: rtl/rmerge_node.sv
module rmerge_node
  import rmerge_pkg::*;
#(
  parameter int NUM_UP = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_UP-1:0]        upReqValid,
  output logic [NUM_UP-1:0]        upReqReady,
  input  logic [NUM_UP*BEAT_W-1:0] upReqData,
  output logic                     dnReqValid,
  input  logic                     dnReqReady,
  output logic [BEAT_W-1:0]        dnReqData,
  input  logic                     dnRspValid,
  output logic                     dnRspReady,
  input  logic [BEAT_W-1:0]        dnRspData,
  output logic [NUM_UP-1:0]        upRspValid,
  input  logic [NUM_UP-1:0]        upRspReady,
  output logic [NUM_UP*BEAT_W-1:0] upRspData
);
  mrg_strobe_t strb;
  mrg_hdr_t    info;

  rmerge_ctrl #(.NUM_UP(NUM_UP)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .upReqValid(upReqValid),
    .upReqReady(upReqReady),
    .dnReqValid(dnReqValid),
    .dnReqReady(dnReqReady),
    .dnRspValid(dnRspValid),
    .dnRspReady(dnRspReady),
    .upRspValid(upRspValid),
    .upRspReady(upRspReady),
    .info      (info),
    .strb      (strb)
  );

  rmerge_dp #(.NUM_UP(NUM_UP)) u_dp (
    .upReqData(upReqData),
    .dnReqData(dnReqData),
    .dnRspData(dnRspData),
    .upRspData(upRspData),
    .strb     (strb),
    .info     (info)
  );
endmodule

// File: rtl/rmerge_node_chk.sv
module rmerge_node_chk #(
  parameter int NUM_UP = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_UP-1:0] upReqValid,
  input logic [NUM_UP-1:0] upReqReady,
  input logic              dnReqValid,
  input logic              dnReqReady,
  input logic [63:0]       dnReqData,
  input logic              dnRspValid,
  input logic              dnRspReady,
  input logic [NUM_UP-1:0] upRspValid,
  input logic [NUM_UP-1:0] upRspReady
);
  a_r5_valid_needs_source: assert property (@(posedge clk) disable iff (!rstN)
    dnReqValid |-> (upReqValid != '0));

  a_r5_ready_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(upReqReady));

  a_r5_ready_only_on_transfer: assert property (@(posedge clk) disable iff (!rstN)
    (upReqReady != '0) |-> (dnReqValid && dnReqReady));

  a_r5_stall_holds_beat: assert property (@(posedge clk) disable iff (!rstN)
    (dnReqValid && !dnReqReady) |=> (dnReqValid && $stable(dnReqData)));

  a_r7_rsp_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(upRspValid));

  a_r7_rsp_needs_source: assert property (@(posedge clk) disable iff (!rstN)
    (upRspValid != '0) |-> dnRspValid);

  a_r9_rsp_transfer_lands: assert property (@(posedge clk) disable iff (!rstN)
    (dnRspValid && dnRspReady) |-> ((upRspValid & upRspReady) != '0));
endmodule

bind rmerge_node rmerge_node_chk #(.NUM_UP(NUM_UP)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .upReqValid(upReqValid),
  .upReqReady(upReqReady),
  .dnReqValid(dnReqValid),
  .dnReqReady(dnReqReady),
  .dnReqData (dnReqData),
  .dnRspValid(dnRspValid),
  .dnRspReady(dnRspReady),
  .upRspValid(upRspValid),
  .upRspReady(upRspReady)
);

// File: tb/rmerge_node_bench.sv
module rmerge_node_bench;
  localparam int NUM = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN;
  logic [NUM-1:0]    upReqValid, upReqReady, upRspValid, upRspReady;
  logic [NUM*64-1:0] upReqData, upRspData;
  logic              dnReqValid, dnReqReady, dnRspValid, dnRspReady;
  logic [63:0]       dnReqData, dnRspData;

  rmerge_node #(.NUM_UP(NUM)) u_rmerge_node (
    .clk(clk), .rstN(rstN),
    .upReqValid(upReqValid), .upReqReady(upReqReady), .upReqData(upReqData),
    .dnReqValid(dnReqValid), .dnReqReady(dnReqReady), .dnReqData(dnReqData),
    .dnRspValid(dnRspValid), .dnRspReady(dnRspReady), .dnRspData(dnRspData),
    .upRspValid(upRspValid), .upRspReady(upRspReady), .upRspData(upRspData)
  );

  typedef struct {
    logic [63:0] d;
    bit          hdr;
  } beat_t;

  beat_t reqQ[NUM][$];
  beat_t rspQ[$];
  bit    vReq[NUM];
  bit    vRsp;
  int    validPct = 100, readyPct = 100, rspReadyPct = 100;
  int    compared = 0, mismatched = 0, cyc = 0;
  int    mCur = -1, mLast = NUM - 1, mRem = 0;
  int    rCur = -1, rRem = 0;
  int    hdrLog[$];

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  function automatic int rrPick();
    for (int k = 1; k <= NUM; k++) begin
      int p;
      p = (mLast + k) % NUM;
      if (vReq[p]) return p;
    end
    return -1;
  endfunction

  function automatic logic [63:0] stampHdr(logic [63:0] h, int p);
    logic [63:0] r;
    r = h;
    r[63:56] = {h[61:56], 2'(p)};
    return r;
  endfunction

  function automatic logic [63:0] popHdr(logic [63:0] h);
    logic [63:0] r;
    r = h;
    r[63:56] = {2'b00, h[63:58]};
    return r;
  endfunction

  task automatic pushReq(int port, bit wr, int len);
    beat_t b;
    logic [63:0] rnd;
    rnd = {$urandom, $urandom};
    b.d = {8'($urandom), wr, 1'b0, 6'(len), rnd[47:0]};
    b.hdr = 1'b1;
    reqQ[port].push_back(b);
    if (wr) for (int j = 0; j < len; j++) begin
      b.d = {$urandom, $urandom};
      b.hdr = 1'b0;
      reqQ[port].push_back(b);
    end
  endtask

  task automatic pushRsp(bit wr, int len);
    beat_t b;
    logic [63:0] rnd;
    rnd = {$urandom, $urandom};
    b.d = {8'($urandom), wr, 1'b1, 6'(len), rnd[47:0]};
    b.hdr = 1'b1;
    rspQ.push_back(b);
    if (!wr) for (int j = 0; j < len; j++) begin
      b.d = {$urandom, $urandom};
      b.hdr = 1'b0;
      rspQ.push_back(b);
    end
  endtask

  task automatic step();
    int p, rp;
    bit expReqFire, expRspFire, aRspFire;
    bit aReqFire[NUM];
    beat_t b;
    logic [63:0] exp;
    @(negedge clk);
    for (int i = 0; i < NUM; i++) begin
      if (!vReq[i] && reqQ[i].size() > 0 && $urandom_range(99) < validPct) vReq[i] = 1'b1;
      upReqValid[i] = vReq[i];
      upReqData[i*64 +: 64] = (reqQ[i].size() > 0) ? reqQ[i][0].d : 64'd0;
      upRspReady[i] = ($urandom_range(99) < rspReadyPct);
    end
    if (!vRsp && rspQ.size() > 0 && $urandom_range(99) < validPct) vRsp = 1'b1;
    dnRspValid = vRsp;
    dnRspData  = (rspQ.size() > 0) ? rspQ[0].d : 64'd0;
    dnReqReady = ($urandom_range(99) < readyPct);
    #1;
    // request path expectations
    p = (mCur >= 0) ? mCur : rrPick();
    expReqFire = 1'b0;
    check(dnReqValid === ((p >= 0) && vReq[p]), "R5", "dnReqValid", 64'(dnReqValid), 64'((p >= 0) && vReq[p]));
    for (int i = 0; i < NUM; i++) begin
      bit er;
      er = (i == p) && vReq[p] && dnReqReady;
      check(upReqReady[i] === er, "R5", $sformatf("upReqReady[%0d]", i), 64'(upReqReady[i]), 64'(er));
      aReqFire[i] = upReqValid[i] && upReqReady[i];
    end
    if (p >= 0 && vReq[p]) begin
      b = reqQ[p][0];
      exp = b.hdr ? stampHdr(b.d, p) : b.d;
      check(dnReqData === exp, b.hdr ? "R2" : "R4", "dnReqData", dnReqData, exp);
      expReqFire = dnReqReady;
    end
    // response path expectations
    rp = (rCur >= 0) ? rCur : (vRsp ? int'(rspQ[0].d[57:56]) : -1);
    for (int i = 0; i < NUM; i++)
      check(upRspValid[i] === (vRsp && i == rp), "R7", $sformatf("upRspValid[%0d]", i),
            64'(upRspValid[i]), 64'(vRsp && i == rp));
    expRspFire = 1'b0;
    if (vRsp) begin
      check(dnRspReady === upRspReady[rp], "R9", "dnRspReady", 64'(dnRspReady), 64'(upRspReady[rp]));
      b = rspQ[0];
      exp = b.hdr ? popHdr(b.d) : b.d;
      check(upRspData[rp*64 +: 64] === exp, b.hdr ? "R7" : "R8", "upRspData", upRspData[rp*64 +: 64], exp);
      expRspFire = upRspReady[rp];
    end
    aRspFire = dnRspValid && dnRspReady;
    for (int i = 0; i < NUM; i++)
      if (aReqFire[i] && reqQ[i][0].hdr) hdrLog.push_back(int'(dnReqData[57:56]));
    @(posedge clk);
    #1;
    // model state update
    if (expReqFire) begin
      b = reqQ[p][0];
      if (b.hdr) begin
        mLast = p;
        if (b.d[55] && b.d[53:48] != 0) begin mCur = p; mRem = int'(b.d[53:48]); end
        else mCur = -1;
      end else begin
        mRem--;
        if (mRem == 0) mCur = -1;
      end
    end else if (p >= 0 && vReq[p] && reqQ[p][0].hdr) begin
      mCur = p;
    end
    if (expRspFire) begin
      b = rspQ[0];
      if (b.hdr) begin
        if (!b.d[55] && b.d[53:48] != 0) begin rCur = rp; rRem = int'(b.d[53:48]); end
        else rCur = -1;
      end else begin
        rRem--;
        if (rRem == 0) rCur = -1;
      end
    end
    for (int i = 0; i < NUM; i++)
      if (aReqFire[i]) begin void'(reqQ[i].pop_front()); vReq[i] = 1'b0; end
    if (aRspFire) begin void'(rspQ.pop_front()); vRsp = 1'b0; end
  endtask

  function automatic bit allEmpty();
    bit e;
    e = (rspQ.size() == 0);
    for (int i = 0; i < NUM; i++) if (reqQ[i].size() != 0) e = 1'b0;
    return e;
  endfunction

  initial begin
    rstN = 1'b0;
    upReqValid = '0; upReqData = '0; upRspReady = '0;
    dnReqReady = 1'b0; dnRspValid = 1'b0; dnRspData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(dnReqValid === 1'b0, "R1", "dnReqValid after reset", 64'(dnReqValid), 64'd0);
    check(upReqReady === '0, "R1", "upReqReady after reset", 64'(upReqReady), 64'd0);
    check(upRspValid === '0, "R1", "upRspValid after reset", 64'(upRspValid), 64'd0);

    // R3: all ports contend right after reset, port 0 first
    for (int i = 0; i < NUM; i++) pushReq(i, 1'b0, 3);
    hdrLog.delete();
    repeat (6) step();
    check(hdrLog.size() == NUM, "R3", "grant count", 64'(hdrLog.size()), 64'(NUM));
    for (int i = 0; i < NUM; i++)
      if (i < hdrLog.size()) check(hdrLog[i] == i, "R3", "grant order", 64'(hdrLog[i]), 64'(i));

    // R6: back-to-back reads from one port
    hdrLog.delete();
    for (int j = 0; j < 3; j++) pushReq(2, 1'b0, 1);
    repeat (3) step();
    check(reqQ[2].size() == 0, "R6", "beats left after 3 cycles", 64'(reqQ[2].size()), 64'd0);
    check(hdrLog.size() == 3, "R6", "headers accepted", 64'(hdrLog.size()), 64'd3);

    // random traffic, then heavy backpressure
    for (int phase = 0; phase < 2; phase++) begin
      validPct    = (phase == 0) ? 60 : 80;
      readyPct    = (phase == 0) ? 65 : 20;
      rspReadyPct = (phase == 0) ? 70 : 25;
      for (int c = 0; c < 3000; c++) begin
        if ($urandom_range(99) < 30) begin
          int port;
          port = $urandom_range(NUM - 1);
          if (reqQ[port].size() < 8) pushReq(port, 1'($urandom_range(1)), $urandom_range(5));
        end
        if ($urandom_range(99) < 20 && rspQ.size() < 8)
          pushRsp(1'($urandom_range(1)), $urandom_range(5));
        step();
      end
    end

    // drain
    validPct = 100; readyPct = 100; rspReadyPct = 100;
    for (int c = 0; c < 2000 && !allEmpty(); c++) step();
    for (int i = 0; i < NUM; i++)
      check(reqQ[i].size() == 0, "R4", $sformatf("request queue %0d drained", i), 64'(reqQ[i].size()), 64'd0);
    check(rspQ.size() == 0, "R8", "response queue drained", 64'(rspQ.size()), 64'd0);
    summary();
  end
endmodule